// File: doc/BRIEF.md
# Stub Second-Level Cache Controller Register Bank

This block presents the register window of a second-level cache controller that does no caching at all, so that boot and driver software which probes, configures and maintains such a controller finds a plausible device and runs to completion. It is a 32-bit APB-style slave. Only the low 12 address bits are decoded, so the 4 KB bank repeats across any larger window it is mapped into. The bus never stalls and always answers OKAY.

The bank holds a constant identification word and a cache-type word. Every read of the cache-type word folds way-size and associativity bits from the auxiliary control register into it, and the folded result is kept. It also holds a one-bit enable register, fully writable auxiliary, tag-RAM and data-RAM control registers, and a pair of address-filter bounds. A whole range of maintenance offsets always reads as "operation finished". A few debug and power offsets quietly read zero. Any access to an offset that the bank does not know sets a sticky error flag, which software can sample as a status line.

Top module: `ghost_cache_regs`

## Requirements
- R1: Only `pAddr[11:0]` selects a register; an access whose low 12 bits match a register reaches that register whatever the upper address bits are.
- R2: A read at offset 0x000 returns 0x410000C8. A write to 0x000 or 0x004 changes no register and sets the error flag.
- R3: A read at offset 0x004 returns `T | (f << 18) | (f << 6)`, where T is the stored cache-type value (reset value 0x1C100100) and f is the 5-bit field {aux[19:17], 1'b0, aux[16]} of the auxiliary control register.
- R4: At the access-phase clock edge of a read at 0x004, the value returned is written back into T. Set bits therefore accumulate over reads, and only reset restores 0x1C100100.
- R5: Every offset from 0x730 through 0x7FF reads zero. Writes there change no register and do not set the error flag.
- R6: A write to 0x100 stores only bit 0 of the write data, and a read there returns that bit with bits 31:1 zero. The reset value is 0.
- R7: The registers at 0x104 (auxiliary, reset 0x02020000), 0x108 (tag RAM, reset 0), 0x10C (data RAM, reset 0), 0xC00 (filter start, reset 0) and 0xC04 (filter end, reset 0) each store and return all 32 written bits.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read zero, ignore writes and do not set the error flag.
- R9: An access to any other offset reads zero and changes no register. It sets `badAccess` at that access-phase edge, and the flag stays at 1 until reset. The flag is 0 after reset.
- R10: `pReady` is always 1. A register changes only on a clock edge where `pSel`, `pEnable` and `pWrite` are all 1, so a write held in the setup phase has no effect.
- R11: `pRData` carries read data only while `pSel` and `pEnable` are both 1, and is zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pSel | input | 1 | Slave select |
| pEnable | input | 1 | Access-phase marker |
| pWrite | input | 1 | 1 for write, 0 for read |
| pAddr | input | 32 | Byte address; low 12 bits decoded |
| pWData | input | 32 | Write data |
| pRData | output | 32 | Read data, combinational in the access phase |
| pReady | output | 1 | Constant 1, no wait states |
| badAccess | output | 1 | Sticky unknown-offset flag |

## Verification
Read data is due in the access phase itself, before the clock edge that closes the transfer. The monitor therefore samples `pRData` one time unit after the falling edge that raises `pEnable`, and compares it with the value the driver queued for that transfer. Register updates, cache-type accumulation and the error flag all take effect at the access-phase rising edge. They are checked by a later read transfer, or by sampling `badAccess` at the falling edge that ends the transfer. Because the error flag is sticky, every no-error case runs before the first bad offset, and reset is applied again before each further bad-offset case.

// File: rtl/ghost_cache_pkg.sv
package ghost_cache_pkg;

  localparam int OFFS_W = 12;

  localparam logic [OFFS_W-1:0] OFF_ID      = 12'h000;
  localparam logic [OFFS_W-1:0] OFF_TYPE    = 12'h004;
  localparam logic [OFFS_W-1:0] OFF_ENABLE  = 12'h100;
  localparam logic [OFFS_W-1:0] OFF_AUX     = 12'h104;
  localparam logic [OFFS_W-1:0] OFF_TAGRAM  = 12'h108;
  localparam logic [OFFS_W-1:0] OFF_DATRAM  = 12'h10C;
  localparam logic [OFFS_W-1:0] OFF_FLT_LO  = 12'hC00;
  localparam logic [OFFS_W-1:0] OFF_FLT_HI  = 12'hC04;
  localparam logic [OFFS_W-1:0] OFF_QUIET0  = 12'hF40;
  localparam logic [OFFS_W-1:0] OFF_QUIET1  = 12'hF60;
  localparam logic [OFFS_W-1:0] OFF_QUIET2  = 12'hF80;
  localparam logic [OFFS_W-1:0] MAINT_FIRST = 12'h730;
  localparam logic [OFFS_W-1:0] MAINT_LAST  = 12'h7FF;

  localparam int FOLD_LO_POS = 6;
  localparam int FOLD_HI_POS = 18;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ID, SEL_TYPE, SEL_ENABLE, SEL_AUX,
    SEL_TAGRAM, SEL_DATRAM, SEL_FLT_LO, SEL_FLT_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrAux;
    logic   wrTagRam;
    logic   wrDatRam;
    logic   wrFltLo;
    logic   wrFltHi;
    logic   typeFold;
    logic   markBad;
    rdSel_e rdSel;
  } strobe_t;

  // Way-size and associativity bits of aux, packed into a 5-bit field
  // and placed at two positions of the cache-type word.
  function automatic logic [31:0] foldMask(input logic [31:0] aux);
    logic [4:0] fld;
    fld = {aux[19:17], 1'b0, aux[16]};
    return (32'(fld) << FOLD_HI_POS) | (32'(fld) << FOLD_LO_POS);
  endfunction

endpackage

// File: rtl/ghost_cache_ctrl.sv
module ghost_cache_ctrl
  import ghost_cache_pkg::*;
#(
  parameter int OFF_W = OFFS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pSel,
  input  logic             pEnable,
  input  logic             pWrite,
  input  logic [OFF_W-1:0] offset,
  output strobe_t          strb
);

  typedef enum logic [1:0] {REG_KNOWN, REG_QUIET, REG_BAD} region_e;

  logic    access;
  logic    rdAcc;
  logic    wrAcc;
  logic    inMaint;
  region_e region;
  rdSel_e  target;

  assign access  = pSel && pEnable;
  assign rdAcc   = access && !pWrite;
  assign wrAcc   = access && pWrite;
  assign inMaint = (offset >= MAINT_FIRST) && (offset <= MAINT_LAST);

  always_comb begin
    target = SEL_ZERO;
    region = REG_BAD;
    if (inMaint) begin
      region = REG_QUIET;
    end else begin
      unique case (offset)
        OFF_ID:     begin target = SEL_ID;     region = REG_KNOWN; end
        OFF_TYPE:   begin target = SEL_TYPE;   region = REG_KNOWN; end
        OFF_ENABLE: begin target = SEL_ENABLE; region = REG_KNOWN; end
        OFF_AUX:    begin target = SEL_AUX;    region = REG_KNOWN; end
        OFF_TAGRAM: begin target = SEL_TAGRAM; region = REG_KNOWN; end
        OFF_DATRAM: begin target = SEL_DATRAM; region = REG_KNOWN; end
        OFF_FLT_LO: begin target = SEL_FLT_LO; region = REG_KNOWN; end
        OFF_FLT_HI: begin target = SEL_FLT_HI; region = REG_KNOWN; end
        OFF_QUIET0, OFF_QUIET1, OFF_QUIET2: region = REG_QUIET;
        default: region = REG_BAD;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = rdAcc ? target : SEL_ZERO;
    strb.wrEnable = wrAcc && (target == SEL_ENABLE);
    strb.wrAux    = wrAcc && (target == SEL_AUX);
    strb.wrTagRam = wrAcc && (target == SEL_TAGRAM);
    strb.wrDatRam = wrAcc && (target == SEL_DATRAM);
    strb.wrFltLo  = wrAcc && (target == SEL_FLT_LO);
    strb.wrFltHi  = wrAcc && (target == SEL_FLT_HI);
    strb.typeFold = rdAcc && (target == SEL_TYPE);
    // identification and cache-type words are read-only: writing them is bad
    strb.markBad  = access && ((region == REG_BAD) ||
                    (pWrite && (target == SEL_ID || target == SEL_TYPE)));
  end

  // R5
  maint_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (access && inMaint) |->
      (!strb.markBad && !strb.wrAux && !strb.wrEnable && strb.rdSel == SEL_ZERO));

  // R10
  setup_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pSel && pEnable && pWrite) |->
      !(strb.wrEnable || strb.wrAux || strb.wrTagRam || strb.wrDatRam ||
        strb.wrFltLo || strb.wrFltHi));

endmodule

// File: rtl/ghost_cache_dpath.sv
module ghost_cache_dpath
  import ghost_cache_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] ID_VALUE   = 32'h410000C8,
  parameter logic [31:0] TYPE_RESET = 32'h1C100100,
  parameter logic [31:0] AUX_RESET  = 32'h02020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  output logic              badAccess
);

  localparam int N_WIDE = 5;

  logic              enableBit;
  logic [DATA_W-1:0] typeReg;
  logic [DATA_W-1:0] typeView;
  logic [DATA_W-1:0] wideReg [N_WIDE];
  logic [N_WIDE-1:0] wideWr;

  // order of wideReg: aux, tag RAM, data RAM, filter start, filter end
  assign wideWr = {strb.wrFltHi, strb.wrFltLo, strb.wrDatRam, strb.wrTagRam, strb.wrAux};

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    localparam logic [DATA_W-1:0] RST_VAL = (i == 0) ? DATA_W'(AUX_RESET) : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          wideReg[i] <= RST_VAL;
      else if (wideWr[i]) wideReg[i] <= wData;
    end
  end

  assign typeView = typeReg | DATA_W'(foldMask(32'(wideReg[0])));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableBit <= 1'b0;
      typeReg   <= DATA_W'(TYPE_RESET);
      badAccess <= 1'b0;
    end else begin
      if (strb.wrEnable) enableBit <= wData[0];
      if (strb.typeFold) typeReg   <= typeView;
      if (strb.markBad)  badAccess <= 1'b1;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_ID:     rData = DATA_W'(ID_VALUE);
      SEL_TYPE:   rData = typeView;
      SEL_ENABLE: rData = DATA_W'(enableBit);
      SEL_AUX:    rData = wideReg[0];
      SEL_TAGRAM: rData = wideReg[1];
      SEL_DATRAM: rData = wideReg[2];
      SEL_FLT_LO: rData = wideReg[3];
      SEL_FLT_HI: rData = wideReg[4];
      default:    rData = '0;
    endcase
  end

  // R4
  type_accum_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((typeReg & $past(typeReg)) == $past(typeReg)));

  // R9
  bad_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    badAccess |=> badAccess);

  // R7
  aux_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAux |=> (wideReg[0] == $past(wData)));

  // R6
  enable_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_ENABLE) |-> (rData[DATA_W-1:1] == '0));

endmodule

// File: rtl/ghost_cache_regs.sv
module ghost_cache_regs
  import ghost_cache_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] ID_VALUE   = 32'h410000C8,
  parameter logic [31:0] TYPE_RESET = 32'h1C100100,
  parameter logic [31:0] AUX_RESET  = 32'h02020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWData,
  output logic [DATA_W-1:0] pRData,
  output logic              pReady,
  output logic              badAccess
);

  strobe_t strb;
  logic    unusedAddrHi;

  assign unusedAddrHi = ^pAddr[ADDR_W-1:OFFS_W];
  assign pReady       = 1'b1;

  ghost_cache_ctrl #(.OFF_W(OFFS_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pSel    (pSel),
    .pEnable (pEnable),
    .pWrite  (pWrite),
    .offset  (pAddr[OFFS_W-1:0]),
    .strb    (strb)
  );

  ghost_cache_dpath #(
    .DATA_W     (DATA_W),
    .ID_VALUE   (ID_VALUE),
    .TYPE_RESET (TYPE_RESET),
    .AUX_RESET  (AUX_RESET)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wData     (pWData),
    .rData     (pRData),
    .badAccess (badAccess)
  );

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSel && pEnable && !pWrite && pAddr[OFFS_W-1:0] == OFF_ID) |->
      (pRData == DATA_W'(ID_VALUE)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pSel && pEnable) |-> (pRData == '0));

endmodule

// File: tb/ghost_cache_regs_bench.sv
module ghost_cache_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [31:0] pAddr = '0, pWData = '0;
  logic [31:0] pRData;
  logic        pReady, badAccess;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t expQ[$];

  ghost_cache_regs u_ghost_cache_regs (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .pWData(pWData), .pRData(pRData), .pReady(pReady),
    .badAccess(badAccess)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // independent model of the cache-type fold (R3)
  function automatic logic [31:0] fold(input logic [31:0] aux);
    logic [4:0] f;
    f = {aux[19:17], 1'b0, aux[16]};
    return ({27'd0, f} << 18) | ({27'd0, f} << 6);
  endfunction

  task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                      input logic [31:0] exp, input string req);
    if (!wr) expQ.push_back('{val: exp, req: req});
    @(negedge clk);
    pSel = 1'b1; pEnable = 1'b0; pWrite = wr; pAddr = addr; pWData = wd;
    @(negedge clk);
    pEnable = 1'b1;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
  endtask

  task automatic rd(input logic [31:0] addr, input logic [31:0] exp, input string req);
    xfer(1'b0, addr, '0, exp, req);
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] wd);
    xfer(1'b1, addr, wd, '0, "");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor: compares access-phase read data with the queued expectation
  always @(negedge clk) begin
    #1;
    if (rstN) chk("R10 pReady", {31'd0, pReady}, 32'd1);
    if (pSel && pEnable && !pWrite) begin
      if (expQ.size() == 0) begin
        chk("scoreboard empty", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.req, pRData, e.val);
      end
    end else if (rstN) begin
      chk("R11 idle data", pRData, 32'd0);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] typeModel;
    logic [31:0] auxModel;
    doReset();
    #1;
    chk("R9 reset flag", {31'd0, badAccess}, 32'd0);

    // reset values
    rd(32'h000, 32'h410000C8, "R2 id");
    rd(32'h100, 32'h0, "R6 reset");
    rd(32'h104, 32'h02020000, "R7 aux reset");
    rd(32'h108, 32'h0, "R7 tag reset");
    rd(32'h10C, 32'h0, "R7 data reset");
    rd(32'hC00, 32'h0, "R7 flt lo reset");
    rd(32'hC04, 32'h0, "R7 flt hi reset");

    typeModel = 32'h1C100100;
    auxModel  = 32'h02020000;
    typeModel = typeModel | fold(auxModel);
    rd(32'h004, typeModel, "R3 type default aux");

    // full-width registers
    wr(32'h108, 32'hDEADBEEF);
    wr(32'h10C, 32'h12345678);
    wr(32'hC00, 32'hFFFF0000);
    wr(32'hC04, 32'h0000FFFF);
    rd(32'h108, 32'hDEADBEEF, "R7 tag");
    rd(32'h10C, 32'h12345678, "R7 data");
    rd(32'hC00, 32'hFFFF0000, "R7 flt lo");
    rd(32'hC04, 32'h0000FFFF, "R7 flt hi");

    // enable register keeps bit 0 only
    wr(32'h100, 32'hFFFFFFFF);
    rd(32'h100, 32'h1, "R6 set");
    wr(32'h100, 32'hFFFFFFFE);
    rd(32'h100, 32'h0, "R6 clear");

    // cache-type fold and accumulation
    auxModel = 32'h000F0000;
    wr(32'h104, auxModel);
    rd(32'h104, auxModel, "R7 aux");
    typeModel = typeModel | fold(auxModel);
    rd(32'h004, typeModel, "R3 type folded");
    auxModel = 32'h0;
    wr(32'h104, auxModel);
    rd(32'h004, typeModel | fold(auxModel), "R4 type kept");
    auxModel = 32'h00040000;
    wr(32'h104, auxModel);
    typeModel = typeModel | fold(auxModel);
    rd(32'h004, typeModel, "R4 type accum");

    // aliasing through upper address bits
    rd(32'hABCD_E108, 32'hDEADBEEF, "R1 alias read");
    wr(32'h5000_0C00, 32'hCAFEF00D);
    rd(32'hC00, 32'hCAFEF00D, "R1 alias write");

    // maintenance window and quiet offsets
    rd(32'h730, 32'h0, "R5 maint low");
    rd(32'h7FC, 32'h0, "R5 maint high");
    wr(32'h7F0, 32'hFFFFFFFF);
    wr(32'hF40, 32'hFFFFFFFF);
    wr(32'hF60, 32'hFFFFFFFF);
    rd(32'hF80, 32'h0, "R8 quiet read");
    rd(32'h108, 32'hDEADBEEF, "R8 R5 no side effect");
    #1;
    chk("R5 R8 no flag", {31'd0, badAccess}, 32'd0);

    // setup phase only: no write
    @(negedge clk);
    pSel = 1'b1; pEnable = 1'b0; pWrite = 1'b1; pAddr = 32'h108; pWData = 32'h0;
    repeat (3) @(negedge clk);
    pSel = 1'b0; pWrite = 1'b0;
    rd(32'h108, 32'hDEADBEEF, "R10 setup only");

    // bad offsets
    rd(32'h72C, 32'h0, "R9 bad read data");
    #1;
    chk("R9 flag set", {31'd0, badAccess}, 32'd1);
    rd(32'h100, 32'h0, "R9 flag reg untouched");
    #1;
    chk("R9 sticky", {31'd0, badAccess}, 32'd1);

    doReset();
    #1;
    chk("R9 reset clears", {31'd0, badAccess}, 32'd0);
    rd(32'h004, 32'h1C100100, "R4 reset restores type");
    wr(32'h000, 32'hFFFFFFFF);
    #1;
    chk("R2 write id flags", {31'd0, badAccess}, 32'd1);
    rd(32'h000, 32'h410000C8, "R2 id unchanged");

    doReset();
    wr(32'h800, 32'h11111111);
    #1;
    chk("R9 bad write flag", {31'd0, badAccess}, 32'd1);
    rd(32'h104, 32'h02020000, "R9 bad write no effect");

    done = 1'b1;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule